// File: doc/BRIEF.md
# Edge-Latched Line Condition Status and Interrupt Register

This block sits beside a line receiver and watches four live condition flags: receive clock lost, spare code seen, loop-down code seen and loop-up code seen. Each flag is brought into the register clock domain through a two-stage synchronizer. The synchronized value is then compared with its value one cycle earlier. A transition from low to high sets a sticky "asserted" bit for that flag. A transition from high to low sets a separate sticky "released" bit. The bits stay set until software clears them, so a short pulse on a condition is never lost.

A small synchronous bus gives software access to two 8-bit words: the latched status word and an interrupt enable mask. Status bits are cleared by writing 1s to them. The single interrupt output is a level. It stays high while any status bit is set whose mask bit is also 1.

Top module: `line_event_irq`

## Requirements
- R1: A low-to-high transition of a condition input sets its asserted bit in the status word: bit 3 for clock loss, bit 2 for spare code, bit 1 for loop-down and bit 0 for loop-up.
- R2: A high-to-low transition of a condition input sets its released bit in the status word: bit 7 for clock loss, bit 6 for spare code, bit 5 for loop-down and bit 4 for loop-up.
- R3: A status bit stays set for as long as it is not cleared. Each transition raises exactly one bit, exactly once. A condition held at a steady level raises no bit again after that bit has been cleared.
- R4: A write to address 0 clears every status bit whose write-data bit is 1. Status bits whose write-data bit is 0 keep their value.
- R5: When a transition event and a write-1-to-clear reach the same status bit in the same cycle, the bit ends up set.
- R6: After a synchronous active-low reset, the status word is 0x00, the enable mask is 0x00 and the interrupt output is low.
- R7: A write to address 1 loads the enable mask from the write data. A read at address 1 returns the mask, and a read at address 0 returns the status word.
- R8: The interrupt output is high exactly while status AND mask is non-zero. It falls once every enabled set bit has been cleared.
- R9: Reading has no side effects, and a write to the mask leaves the status word unchanged.
- R10: For an input that changes between two clock edges, the matching status bit becomes visible right after the third rising edge that follows the change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cond_i | input | 4 | Live condition flags: [3] clock loss, [2] spare code, [1] loop-down, [0] loop-up |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 1 | Register select: 0 = status, 1 = enable mask |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register, combinational from the address |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest case to reach from the ports is a write-1-to-clear that lands in the same cycle as a new transition event on the same bit. The event only exists for one cycle, two synchronizer stages after the input changes. To hit it, the bench first sets both latches of loop-up with a rise and a fall. It then raises the input again on a falling clock edge, waits two rising edges, and drives the clear write so that it is sampled on the third edge. The same write also targets the released bit, which shows that the clearing path was active in that cycle.

// File: rtl/line_event_pkg.sv
// Package: shared sizes and register addresses for the line event register block.
// Assumes a one-bit register address space with two registers.
package line_event_pkg;
    localparam int COND_N      = 4;
    localparam int SYNC_DEPTH  = 2;
    localparam int STAT_W      = 2 * COND_N;
    localparam logic ADDR_STATUS = 1'b0;
    localparam logic ADDR_MASK   = 1'b1;
endpackage

// File: rtl/cond_edge_detect.sv
// Module: cond_edge_detect
// Synchronizes each asynchronous condition flag through SYNC_DEPTH flops and
// flags one-cycle rise and fall events by comparing against the previous
// synchronized sample. Assumes inputs are low while reset is applied.
module cond_edge_detect #(
    parameter int N          = 4,
    parameter int SYNC_DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cond_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    localparam int LAST = SYNC_DEPTH - 1;

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [SYNC_DEPTH-1:0] chain_q;
        logic                  prev_q;

        // Shift the flag through the synchronizer and keep the last sample.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= '0;
                prev_q  <= 1'b0;
            end else begin
                chain_q <= {chain_q[LAST-1:0], cond_i[i]};
                prev_q  <= chain_q[LAST];
            end
        end

        assign rise_o[i] = chain_q[LAST] & ~prev_q;
        assign fall_o[i] = ~chain_q[LAST] & prev_q;

        // A rise event lasts one cycle only (R3: each edge seen once).
        assert_rise_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[i] |=> !rise_o[i]);
        assert_fall_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
            fall_o[i] |=> !fall_o[i]);
    end
endmodule

// File: rtl/sticky_w1c_reg.sv
// Module: sticky_w1c_reg
// Holds W sticky status bits. A set pulse latches a bit, and a clear pulse
// removes it unless a set arrives in the same cycle (set has priority).
module sticky_w1c_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] sts_o
);
    logic [W-1:0] sts_q;

    // Update the status bits: clear first, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= (sts_q & ~clr_i) | set_i;
    end

    assign sts_o = sts_q;

    for (genvar b = 0; b < W; b++) begin : g_chk
        assert_event_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[b] |=> sts_q[b]);
        assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[b] && !set_i[b]) |=> !sts_q[b]);
        assert_collision_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[b] && set_i[b]) |=> sts_q[b]);
        assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i[b] && !set_i[b]) |=> $stable(sts_q[b]));
    end
endmodule

// File: rtl/irq_mask_reg.sv
// Module: irq_mask_reg
// Stores the interrupt enable mask and forms the level interrupt request
// from the status word. The request is combinational from status and mask.
module irq_mask_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] sts_i,
    output logic [W-1:0] mask_o,
    output logic         irq_o
);
    logic [W-1:0] mask_q;

    // Load the mask on a write to its address.
    always_ff @(posedge clk) begin
        if (!rst_n)    mask_q <= '0;
        else if (wr_i) mask_q <= wdata_i;
    end

    assign mask_o = mask_q;
    assign irq_o  = |(sts_i & mask_q);

    assert_mask_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (mask_q == $past(wdata_i)));
    assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(mask_q));
endmodule

// File: rtl/line_event_irq.sv
// Module: line_event_irq (top)
// Register block that latches rise and fall events of the line condition flags
// into a write-1-to-clear status word: released events in the upper half,
// asserted events in the lower half. It also holds an interrupt mask.
// Assumes a single-cycle synchronous bus where read data is taken combinationally.
module line_event_irq
    import line_event_pkg::*;
#(
    parameter int N_COND = COND_N,
    parameter int DATA_W = 2 * N_COND
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_COND-1:0] cond_i,
    input  logic              bus_we,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    logic [N_COND-1:0] rise_evt;
    logic [N_COND-1:0] fall_evt;
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] clr_vec;
    logic [DATA_W-1:0] sts;
    logic [DATA_W-1:0] mask;
    logic              wr_sts;
    logic              wr_mask;

    cond_edge_detect #(.N(N_COND), .SYNC_DEPTH(SYNC_DEPTH)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .cond_i (cond_i),
        .rise_o (rise_evt),
        .fall_o (fall_evt)
    );

    // Decode the bus write strobe per register.
    always_comb begin
        wr_sts  = bus_we && (bus_addr == ADDR_STATUS);
        wr_mask = bus_we && (bus_addr == ADDR_MASK);
        set_vec = {fall_evt, rise_evt};
        clr_vec = wr_sts ? bus_wdata : '0;
    end

    sticky_w1c_reg #(.W(DATA_W)) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec),
        .clr_i (clr_vec),
        .sts_o (sts)
    );

    irq_mask_reg #(.W(DATA_W)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_mask),
        .wdata_i (bus_wdata),
        .sts_i   (sts),
        .mask_o  (mask),
        .irq_o   (irq_o)
    );

    // Select read data; reading changes no state.
    always_comb begin
        bus_rdata = (bus_addr == ADDR_MASK) ? mask : sts;
    end

    assert_irq_low_when_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts & mask) == '0) |-> !irq_o);
    assert_irq_high_when_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts & mask) != '0) |-> irq_o);
    assert_mask_write_keeps_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mask && (set_vec == '0)) |=> $stable(sts));
endmodule

// File: tb/line_event_irq_tb.sv
// Directed bench for line_event_irq: one task per scenario, each self-checking.
module line_event_irq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cond = 4'h0;
    logic       we = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    line_event_irq dut_i (
        .clk(clk), .rst_n(rst_n), .cond_i(cond), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0; wdata = 8'h00;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        @(negedge clk); addr = a; #1 d = rdata;
    endtask

    // Change the inputs and wait until the event is latched (three edges).
    task automatic drive_cond(input logic [3:0] v);
        @(negedge clk); cond = v;
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        bus_read(1'b0, d); check("R6 status", d, 8'h00);
        bus_read(1'b1, d); check("R6 mask", d, 8'h00);
        check("R6 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_rise_each();
        logic [7:0] d;
        logic [7:0] exp = 8'h00;
        logic [3:0] v = 4'h0;
        for (int k = 3; k >= 0; k--) begin
            v[k] = 1'b1; exp[k] = 1'b1;
            drive_cond(v);
            bus_read(1'b0, d); check("R1 detect bit", d, exp);
        end
    endtask

    task automatic t_fall_each();
        logic [7:0] d;
        logic [7:0] exp = 8'h0F;
        logic [3:0] v = 4'hF;
        for (int k = 0; k < 4; k++) begin
            v[k] = 1'b0; exp[k+4] = 1'b1;
            drive_cond(v);
            bus_read(1'b0, d); check("R2 release bit", d, exp);
        end
    endtask

    task automatic t_w1c();
        logic [7:0] d;
        bus_write(1'b0, 8'hA5);
        bus_read(1'b0, d); check("R4 partial clear", d, 8'h5A);
        bus_write(1'b0, 8'h00);
        bus_read(1'b0, d); check("R4 zero write", d, 8'h5A);
        bus_write(1'b0, 8'hFF);
        bus_read(1'b0, d); check("R4 full clear", d, 8'h00);
    endtask

    task automatic t_sticky_once();
        logic [7:0] d;
        drive_cond(4'b0100);
        repeat (10) @(posedge clk);
        bus_read(1'b0, d); check("R3 sticky", d, 8'h04);
        bus_write(1'b0, 8'h04);
        repeat (10) @(posedge clk);
        bus_read(1'b0, d); check("R3 no retrigger", d, 8'h00);
        drive_cond(4'b0000);
        bus_write(1'b0, 8'hFF);
    endtask

    task automatic t_latency();
        logic [7:0] d;
        @(negedge clk); cond = 4'b1000;
        repeat (2) @(posedge clk);
        #1 d = rdata; check("R10 not before third edge", d, 8'h00);
        @(posedge clk);
        #1 d = rdata; check("R10 at third edge", d, 8'h08);
        drive_cond(4'b0000);
        bus_write(1'b0, 8'hFF);
    endtask

    task automatic t_collision();
        logic [7:0] d;
        drive_cond(4'b0001);
        drive_cond(4'b0000);
        bus_read(1'b0, d); check("R5 setup", d, 8'h11);
        @(negedge clk); cond = 4'b0001;
        repeat (2) @(posedge clk);
        @(negedge clk); we = 1'b1; addr = 1'b0; wdata = 8'h11;
        @(posedge clk);
        #1 we = 1'b0; wdata = 8'h00;
        bus_read(1'b0, d); check("R5 event beats clear", d, 8'h01);
        drive_cond(4'b0000);
        bus_write(1'b0, 8'hFF);
    endtask

    task automatic t_mask_irq();
        logic [7:0] d;
        bus_write(1'b1, 8'h3C);
        bus_read(1'b1, d); check("R7 mask readback", d, 8'h3C);
        bus_read(1'b0, d); check("R9 mask write keeps status", d, 8'h00);
        check("R8 no status irq low", {7'd0, irq}, 8'h00);
        drive_cond(4'b0010);
        bus_read(1'b0, d); check("R8 setup", d, 8'h02);
        check("R8 unmasked bit irq low", {7'd0, irq}, 8'h00);
        bus_write(1'b1, 8'h02);
        check("R8 enabled bit irq high", {7'd0, irq}, 8'h01);
        bus_read(1'b1, d); bus_read(1'b0, d); bus_read(1'b0, d);
        check("R9 reads no side effect", d, 8'h02);
        check("R8 irq held", {7'd0, irq}, 8'h01);
        bus_write(1'b0, 8'h02);
        check("R8 irq drops on clear", {7'd0, irq}, 8'h00);
        drive_cond(4'b0000);
        bus_write(1'b0, 8'hFF);
        bus_write(1'b1, 8'h00);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_rise_each();
        t_fall_each();
        t_w1c();
        t_sticky_once();
        t_latency();
        t_collision();
        t_mask_irq();
        finish_run();
    end
endmodule